// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

A register-mapped timer with one shared free-running counter and a small set of compare channels. Each channel raises an interrupt when the counter reaches its compare value. It can fire once, or it can rearm itself by adding a stored period after each hit. Software reaches every register through a single-cycle bus with an address, write data, a write strobe and combinational read data. Each channel drives its own interrupt line.

Register word addresses: 0 capability (read-only), 1 global control, 2 interrupt status, 3 counter. Channel n has its control word at 4+2n and its compare word at 5+2n.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter is stopped and reads 0. Global control and status read 0. Each channel is one-shot with interrupts off, its compare reads 0, and no interrupt line is high.
- R2: The capability word holds three fields. Bits [4:0] give the channel count minus one. Bit 8 is 1 when the counter is 64 bits wide. Bits [63:32] give the tick period in femtoseconds. With the default parameters it reads 0x0429B17F_00000102.
- R3: Bit 0 of global control runs the counter, which then advances by one each clock. A counter write takes effect only while the counter is stopped; while it runs, the write is ignored.
- R4: Compare and channel-control writes never change the counter value.
- R5: A one-shot channel fires when the running counter equals its compare value. It then stays idle, even if the counter passes that value again, until software writes a new compare value.
- R6: A channel can be periodic (control bit 1) only if it is periodic-capable. When such a channel has the value-set bit (control bit 4) written as 1, the next compare write loads the first fire time. Compare writes after that load the period. On each hit the compare value advances by the period, and the status bit is set on every hit.
- R7: On a channel that is not periodic-capable, control bit 1 is ignored: it reads back 0, and every compare write simply replaces the compare value.
- R8: Control bit 3 forces 32-bit operation. Compare writes are then truncated to 32 bits, only the low 32 counter bits are matched, and the periodic sum wraps at 32 bits.
- R9: Status bit n belongs to channel n. Writing 1 to a bit clears it and writing 0 has no effect. If a hit and a clear of the same bit fall in one cycle, the bit ends up set.
- R10: In level mode (control bit 2 = 1), the interrupt line equals the status bit ANDed with the enable (control bit 0). In edge mode the line is a one-cycle pulse in the cycle after the hit, also gated by the enable. The interrupt line never rises while the enable is 0.
- R11: The channel control word reads back enable, periodic, level and 32-bit at bits 0..3. Value-set reads as 0. Bit 5 is the read-only periodic-capable flag, and bits [47:32] are the read-only routing-capability field (0xC000 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 64 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 64 | Read data for addr_i, combinational |
| irq_o | output | N_CH | Interrupt line per channel |

## Verification
The two functions that can fall in the same cycle are a channel's hit setting its status bit and a software write-1 clearing that same bit. The bench stops the counter, preloads it to 100, arms channel 0 at 105 and then starts the counter. It counts clock edges so that the clear write lands on exactly the edge where the hit is registered. It then judges the result by reading status back and sampling the level interrupt. Both must still show the bit set, and a later clear with no hit must drop it.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned BUS_W = 64;

  localparam int unsigned A_CAP  = 0;
  localparam int unsigned A_GCFG = 1;
  localparam int unsigned A_STS  = 2;
  localparam int unsigned A_CNT  = 3;
  localparam int unsigned A_CH0  = 4;

  localparam int unsigned CFG_IE    = 0;
  localparam int unsigned CFG_PER   = 1;
  localparam int unsigned CFG_LVL   = 2;
  localparam int unsigned CFG_W32   = 3;
  localparam int unsigned CFG_VSET  = 4;
  localparam int unsigned CFG_PCAP  = 5;
  localparam int unsigned CFG_ROUTE = 32;

  typedef struct packed {
    logic ie;
    logic per;
    logic lvl;
    logic w32;
  } ch_cfg_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (run_i) cnt_o <= cnt_o + 1'b1;
    else if (ld_i)  cnt_o <= ld_val_i;
  end
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 64,
  parameter bit          PER_CAP   = 1'b1,
  parameter logic [15:0] ROUTE_CAP = 16'hC000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cfg_we_i,
  input  logic             cmp_we_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] cfg_rd_o,
  output logic [BUS_W-1:0] cmp_rd_o,
  output logic             fire_o,
  output logic             ie_o,
  output logic             lvl_o
);
  ch_cfg_t          cfg_q;
  logic             vset_q, armed_q;
  logic [CNT_W-1:0] cmp_q, per_q, mask, cmp_eff, wd;

  assign mask    = cfg_q.w32 ? CNT_W'(32'hFFFF_FFFF) : {CNT_W{1'b1}};
  assign cmp_eff = cmp_q & mask;
  assign wd      = wdata_i[CNT_W-1:0] & mask;
  assign fire_o  = armed_q & run_i & ((cnt_i & mask) == cmp_eff);
  assign ie_o    = cfg_q.ie;
  assign lvl_o   = cfg_q.lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      vset_q  <= 1'b0;
      armed_q <= 1'b0;
      cmp_q   <= '0;
      per_q   <= '0;
    end else begin
      if (cfg_we_i) begin
        cfg_q.ie  <= wdata_i[CFG_IE];
        cfg_q.per <= wdata_i[CFG_PER] & PER_CAP;
        cfg_q.lvl <= wdata_i[CFG_LVL];
        cfg_q.w32 <= wdata_i[CFG_W32];
        vset_q    <= wdata_i[CFG_VSET] & PER_CAP;
      end
      if (cmp_we_i) begin
        if (cfg_q.per && vset_q) begin
          cmp_q   <= wd;   // first fire time into accumulator
          vset_q  <= 1'b0;
          armed_q <= 1'b1;
        end else if (cfg_q.per) begin
          per_q   <= wd;
        end else begin
          cmp_q   <= wd;
          armed_q <= 1'b1;
        end
      end else if (fire_o) begin
        if (cfg_q.per) cmp_q   <= (cmp_eff + per_q) & mask;
        else           armed_q <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_rd_o                     = '0;
    cfg_rd_o[CFG_IE]             = cfg_q.ie;
    cfg_rd_o[CFG_PER]            = cfg_q.per;
    cfg_rd_o[CFG_LVL]            = cfg_q.lvl;
    cfg_rd_o[CFG_W32]            = cfg_q.w32;
    cfg_rd_o[CFG_PCAP]           = PER_CAP;
    cfg_rd_o[CFG_ROUTE +: 16]    = ROUTE_CAP;
  end

  assign cmp_rd_o = BUS_W'(cmp_eff);
endmodule

// File: rtl/evt_status.sv
module evt_status #(
  parameter int unsigned N_CH = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] fire_i,
  input  logic            clr_i,
  input  logic [N_CH-1:0] clr_mask_i,
  input  logic [N_CH-1:0] ie_i,
  input  logic [N_CH-1:0] lvl_i,
  output logic [N_CH-1:0] status_o,
  output logic [N_CH-1:0] irq_o
);
  logic [N_CH-1:0] pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      pulse_q  <= '0;
    end else begin
      // a hit in the same cycle as a clear keeps the bit set
      status_o <= (status_o & ~(clr_mask_i & {N_CH{clr_i}})) | fire_i;
      pulse_q  <= fire_i;
    end
  end

  assign irq_o = ie_i & ((lvl_i & status_o) | (~lvl_i & pulse_q));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned N_CH         = 3,
  parameter int unsigned CNT_W        = 64,
  parameter int unsigned ADDR_W       = 6,
  parameter logic [31:0] PERIOD_FS    = 32'd69841279,
  parameter logic [N_CH-1:0] PER_CAP_MASK = 3'b011,
  parameter logic [15:0] ROUTE_CAP    = 16'hC000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  localparam logic [4:0]       NCH_M1   = 5'(N_CH - 1);
  localparam logic             WIDE     = (CNT_W == 64);
  localparam logic [BUS_W-1:0] CAP_WORD = {PERIOD_FS, 23'b0, WIDE, 3'b0, NCH_M1};

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [N_CH-1:0]  fire, status, ie_vec, lvl_vec;
  logic [BUS_W-1:0] cfg_rd [N_CH];
  logic [BUS_W-1:0] cmp_rd [N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  run_q <= 1'b0;
    else if (we_i && addr_i == ADDR_W'(A_GCFG))   run_q <= wdata_i[0];
  end

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .ld_i     (we_i && addr_i == ADDR_W'(A_CNT)),
    .ld_val_i (wdata_i[CNT_W-1:0]),
    .cnt_o    (cnt_q)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    evt_channel #(
      .CNT_W     (CNT_W),
      .PER_CAP   (PER_CAP_MASK[g]),
      .ROUTE_CAP (ROUTE_CAP)
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_q),
      .cnt_i    (cnt_q),
      .cfg_we_i (we_i && addr_i == ADDR_W'(A_CH0 + 2*g)),
      .cmp_we_i (we_i && addr_i == ADDR_W'(A_CH0 + 2*g + 1)),
      .wdata_i  (wdata_i),
      .cfg_rd_o (cfg_rd[g]),
      .cmp_rd_o (cmp_rd[g]),
      .fire_o   (fire[g]),
      .ie_o     (ie_vec[g]),
      .lvl_o    (lvl_vec[g])
    );
  end

  evt_status #(.N_CH(N_CH)) u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .clr_i      (we_i && addr_i == ADDR_W'(A_STS)),
    .clr_mask_i (wdata_i[N_CH-1:0]),
    .ie_i       (ie_vec),
    .lvl_i      (lvl_vec),
    .status_o   (status),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if      (addr_i == ADDR_W'(A_CAP))  rdata_o = CAP_WORD;
    else if (addr_i == ADDR_W'(A_GCFG)) rdata_o = BUS_W'(run_q);
    else if (addr_i == ADDR_W'(A_STS))  rdata_o = BUS_W'(status);
    else if (addr_i == ADDR_W'(A_CNT))  rdata_o = BUS_W'(cnt_q);
    else begin
      for (int i = 0; i < N_CH; i++) begin
        if (addr_i == ADDR_W'(A_CH0 + 2*i))     rdata_o = cfg_rd[i];
        if (addr_i == ADDR_W'(A_CH0 + 2*i + 1)) rdata_o = cmp_rd[i];
      end
    end
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [63:0]       wdata_i,
  input logic              we_i,
  input logic              run_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [N_CH-1:0]   fire_i,
  input logic [N_CH-1:0]   status_i,
  input logic [N_CH-1:0]   ie_i,
  input logic [N_CH-1:0]   irq_i
);
  logic cnt_wr, cmp_wr, sts_wr;
  assign cnt_wr = we_i && addr_i == ADDR_W'(3);
  assign cmp_wr = we_i && addr_i[0] && addr_i >= ADDR_W'(4) && addr_i < ADDR_W'(4 + 2*N_CH);
  assign sts_wr = we_i && addr_i == ADDR_W'(2);

  a_r3_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr) |=> $stable(cnt_i));

  a_r3_run_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  a_r4_cmp_no_touch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_wr && !run_i) |=> cnt_i == $past(cnt_i));

  a_r10_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i & ~ie_i) == '0);

  for (genvar n = 0; n < N_CH; n++) begin : g_n
    a_r9_hit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i[n] |=> status_i[n]);
    a_r9_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_wr && wdata_i[n] && !fire_i[n]) |=> !status_i[n]);
    a_r9_w0_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_wr && !wdata_i[n] && status_i[n]) |=> status_i[n]);
  end
endmodule

bind evt_timer evt_timer_chk #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .we_i     (we_i),
  .run_i    (run_q),
  .cnt_i    (cnt_q),
  .fire_i   (fire),
  .status_i (status),
  .ie_i     (ie_vec),
  .irq_i    (irq_o)
);

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
  localparam int NV = 54;
  // {op[1:0] (0 write,1 read-check,2 idle), req[3:0], addr[7:0], data[63:0], expect[63:0]}
  localparam logic [141:0] VEC [NV] = '{
    {2'd1, 4'd2,  8'd0, 64'd0, 64'h0429B17F_00000102},          // R2 capability
    {2'd0, 4'd6,  8'd4, 64'd23, 64'd0},                         // R6 ch0 ie|per|lvl|vset
    {2'd0, 4'd6,  8'd5, 64'd10, 64'd0},                         // R6 first fire time
    {2'd0, 4'd6,  8'd5, 64'd8, 64'd0},                          // R6 period
    {2'd1, 4'd11, 8'd4, 64'd0, 64'h0000C000_00000027},          // R11 cfg layout
    {2'd0, 4'd3,  8'd1, 64'd1, 64'd0},                          // R3 run
    {2'd2, 4'd6,  8'd0, 64'd19, 64'd0},
    {2'd0, 4'd3,  8'd1, 64'd0, 64'd0},                          // R3 stop
    {2'd1, 4'd3,  8'd3, 64'd0, 64'd20},                         // R3 count
    {2'd1, 4'd6,  8'd5, 64'd0, 64'd26},                         // R6 two reloads
    {2'd1, 4'd6,  8'd2, 64'd0, 64'd1},                          // R6 status
    {2'd0, 4'd9,  8'd2, 64'd0, 64'd0},                          // R9 write 0
    {2'd1, 4'd9,  8'd2, 64'd0, 64'd1},
    {2'd0, 4'd9,  8'd2, 64'd1, 64'd0},                          // R9 write 1
    {2'd1, 4'd9,  8'd2, 64'd0, 64'd0},
    {2'd0, 4'd5,  8'd4, 64'd0, 64'd0},
    {2'd0, 4'd5,  8'd5, 64'hFFFFFFFF_FFFFFF00, 64'd0},
    {2'd0, 4'd3,  8'd3, 64'h000000AB_FFFFFFEE, 64'd0},
    {2'd0, 4'd8,  8'd6, 64'd26, 64'd0},                         // R8 ch1 per|w32|vset
    {2'd0, 4'd8,  8'd7, 64'h00000001_FFFFFFF0, 64'd0},
    {2'd0, 4'd8,  8'd7, 64'd32, 64'd0},
    {2'd1, 4'd8,  8'd7, 64'd0, 64'h00000000_FFFFFFF0},          // R8 truncated
    {2'd0, 4'd3,  8'd1, 64'd1, 64'd0},
    {2'd2, 4'd8,  8'd0, 64'd3, 64'd0},
    {2'd0, 4'd3,  8'd1, 64'd0, 64'd0},
    {2'd1, 4'd4,  8'd3, 64'd0, 64'h000000AB_FFFFFFF2},          // R4 counter untouched by compare writes
    {2'd1, 4'd8,  8'd7, 64'd0, 64'h10},                         // R8 wrap at 32
    {2'd1, 4'd8,  8'd2, 64'd0, 64'd2},
    {2'd0, 4'd9,  8'd2, 64'd2, 64'd0},
    {2'd0, 4'd5,  8'd6, 64'd0, 64'd0},
    {2'd0, 4'd5,  8'd7, 64'hFFFFFFFF_FFFFFF00, 64'd0},
    {2'd0, 4'd7,  8'd8, 64'd18, 64'd0},                         // R7 ch2 not capable
    {2'd1, 4'd7,  8'd8, 64'd0, 64'h0000C000_00000000},
    {2'd0, 4'd3,  8'd3, 64'd0, 64'd0},
    {2'd0, 4'd7,  8'd9, 64'd5, 64'd0},
    {2'd0, 4'd7,  8'd9, 64'd7, 64'd0},
    {2'd1, 4'd7,  8'd9, 64'd0, 64'd7},                          // R7 compare replaced
    {2'd0, 4'd3,  8'd1, 64'd1, 64'd0},
    {2'd2, 4'd5,  8'd0, 64'd9, 64'd0},
    {2'd0, 4'd3,  8'd1, 64'd0, 64'd0},
    {2'd1, 4'd5,  8'd2, 64'd0, 64'd4},                          // R5 one-shot hit
    {2'd0, 4'd9,  8'd2, 64'd4, 64'd0},
    {2'd0, 4'd3,  8'd3, 64'd0, 64'd0},
    {2'd0, 4'd3,  8'd1, 64'd1, 64'd0},
    {2'd2, 4'd5,  8'd0, 64'd9, 64'd0},
    {2'd0, 4'd3,  8'd1, 64'd0, 64'd0},
    {2'd1, 4'd5,  8'd2, 64'd0, 64'd0},                          // R5 stays idle
    {2'd1, 4'd3,  8'd3, 64'd0, 64'd10},
    {2'd0, 4'd3,  8'd3, 64'd0, 64'd0},
    {2'd0, 4'd3,  8'd1, 64'd1, 64'd0},
    {2'd0, 4'd3,  8'd3, 64'd5, 64'd0},                          // R3 ignored while running
    {2'd0, 4'd3,  8'd1, 64'd0, 64'd0},
    {2'd1, 4'd3,  8'd3, 64'd0, 64'd2},
    {2'd1, 4'd3,  8'd1, 64'd0, 64'd0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [63:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [63:0] rdata_o;
  logic [2:0]  irq_o;
  int nchk = 0, nfail = 0;

  always #4 clk_i = ~clk_i;

  evt_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    addr_i = a[5:0]; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] a, input logic [63:0] e);
    addr_i = a[5:0];
    #1;
    nchk++;
    if (rdata_o !== e) begin
      nfail++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, rdata_o, e);
    end
  endtask

  task automatic chk_irq(input string tag, input logic [2:0] e);
    nchk++;
    if (irq_o !== e) begin
      nfail++;
      $display("FAIL %s irq actual %b expected %b", tag, irq_o, e);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] rq;
      logic [7:0] a;
      logic [63:0] d, e;
      {op, rq, a, d, e} = VEC[i];
      case (op)
        2'd0: wr(a, d);
        2'd1: chk($sformatf("R%0d", rq), a, e);
        default: repeat (int'(d)) @(negedge clk_i);
      endcase
    end

    // R9 hit and clear on the same edge; R10 level line
    wr(8'd4, 64'd5);
    wr(8'd3, 64'd100);
    wr(8'd5, 64'd105);
    wr(8'd1, 64'd1);
    repeat (5) @(negedge clk_i);
    wr(8'd2, 64'd1);
    chk("R9 set wins", 8'd2, 64'd1);
    chk_irq("R10 level", 3'b001);
    wr(8'd4, 64'd4);
    chk_irq("R10 enable off", 3'b000);
    chk("R10 status kept", 8'd2, 64'd1);
    wr(8'd2, 64'd1);
    chk("R9 cleared", 8'd2, 64'd0);
    wr(8'd1, 64'd0);

    // R10 edge pulse
    wr(8'd4, 64'd1);
    wr(8'd3, 64'd200);
    wr(8'd5, 64'd203);
    wr(8'd1, 64'd1);
    repeat (4) @(negedge clk_i);
    chk_irq("R10 edge pulse", 3'b001);
    @(negedge clk_i);
    chk_irq("R10 edge pulse end", 3'b000);
    chk("R10 edge status", 8'd2, 64'd1);
    wr(8'd1, 64'd0);

    // R1 reset state
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 counter", 8'd3, 64'd0);
    chk("R1 control", 8'd1, 64'd0);
    chk("R1 status", 8'd2, 64'd0);
    chk("R1 ch0 cfg", 8'd4, 64'h0000C000_00000020);
    chk("R1 ch0 cmp", 8'd5, 64'd0);
    chk_irq("R1 irq", 3'b000);
    repeat (5) @(negedge clk_i);
    chk("R1 stays stopped", 8'd3, 64'd0);

    summary();
    $finish;
  end
endmodule